// File: doc/BRIEF.md
# Dual-Bank Synchronous Burst Static Memory

This block is a cycle-accurate, synthesizable model of a static memory built from two banks that share one data bus. Each bank stores words of 72 bits, 64 data bits in positions [63:0] and 8 parity bits in positions [71:64]. The parity bits are stored and returned as given; the block does not generate or check parity. Every control input is sampled on the rising edge of one clock: the address, the two active-low bank enables, the active-low write enable, the two burst start strobes, the advance strobe and the burst order select. The output enable and the per-bank sleep inputs act on the data drivers without waiting for a clock.

Reads are flow-through. The stored word for the registered address appears on the output in the cycle that follows the start edge, with no output register in between. A burst covers an aligned group of four words. It costs two cycles for the first word and one cycle for each following word. Only the two lowest address bits step through the group, in linear or interleaved order. Writes are early writes: the word on the input bus at the sampling edge is committed at that edge. Holding the controller start strobe low on every edge turns the memory into a single-access synchronous device. The bidirectional bus is split into an input port, an output port and an output-enable port. Bank depth is 2^AW words: AW is 16 for the full 64K-word banks, and the default is smaller so that the model elaborates quickly.

Top module: `dual_bank_burst_sram`

## Requirements
- R1: Each bank holds 2^AW words of 72 bits (data in [63:0], parity in [71:64]), and a word written to a bank and address reads back unchanged from that bank and address.
- R2: An access starts on any rising edge where startCtrlN or startHostN is low. On that edge the address, bankEnN and writeEnN are registered.
- R3: After a read start edge, the word at the registered address is on dataOut with dataOe high in the cycle that follows that edge. There is no added latency.
- R4: A start edge with writeEnN low stores dataIn at addr in the enabled bank on that edge, and dataOe stays low after any write edge.
- R5: An edge with both start strobes high, advN low and an access active advances the burst by one beat. Address bits above bit 1 never change, and after the fourth beat the offset returns to the starting offset.
- R6: With burstOrder = 1 (linear), the offset at beat k is (start offset + k) mod 4.
- R7: With burstOrder = 0 (interleaved), the offset at beat k is start offset XOR k.
- R8: An advance edge with writeEnN low stores dataIn at the new burst address.
- R9: While startCtrlN is low, every edge starts a new access at addr and advN has no effect.
- R10: Only a bank whose enable (bankEnN[0] for bank 0, bankEnN[1] for bank 1) is sampled low takes part. With both enables high, nothing is written and dataOut is not driven. With both low, bank 1 is used and conflictErr is high for the following cycle only.
- R11: A bank whose sleep bit is high ignores writes and keeps its contents, and it never drives the bus.
- R12: outEnN high forces dataOe low at once, and outEnN low restores the read output without a clock edge.
- R13: While rstN is low, no access is active, dataOe is low and conflictErr is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock, rising edge samples all controls |
| rstN | input | 1 | Active-low synchronous reset of the control state |
| addr | input | AW | Word address |
| bankEnN | input | 2 | Active-low bank enables, bit b for bank b |
| writeEnN | input | 1 | Active-low write enable |
| startCtrlN | input | 1 | Active-low controller burst start strobe |
| startHostN | input | 1 | Active-low processor burst start strobe |
| advN | input | 1 | Active-low burst advance strobe |
| burstOrder | input | 1 | 1 = linear burst order, 0 = interleaved |
| outEnN | input | 1 | Asynchronous active-low output enable |
| sleep | input | 2 | Per-bank sleep, bit b for bank b |
| dataIn | input | 72 | Write data (parity in [71:64]) |
| dataOut | output | 72 | Read data, zero when not driven |
| dataOe | output | 1 | High when the bus is driven |
| conflictErr | output | 1 | One-cycle flag after both enables were sampled low |

## Verification
On every cycle the assertions check how the burst walks its group: the upper address bits stay fixed, a linear step adds one, and an interleaved step changes the offset by the XOR of consecutive beat counts. They also check that single-access mode never leaves beat zero, that a double enable selects bank 1 and raises the flag, that no write reaches a sleeping bank, and that the bus stays quiet after writes, under output disable and for sleeping banks. Only the bench scenarios can show that stored words return intact in both burst orders and through wraparound, that a sleeping or deselected bank keeps its old contents, and that the flow-through data arrives one edge after the address is registered. For these the bench compares every read with a reference array.

// File: rtl/sram2b_pkg.sv
package sram2b_pkg;

  // Strobes from the control path to the storage datapath.
  typedef struct packed {
    logic [1:0] wrStrobe;  // per-bank write commit this edge
    logic       rdActive;  // a read access is registered
    logic       rdBank;    // bank addressed by the registered access
  } memStrobe_t;

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sram2b_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    bankEnN,
  input  logic          writeEnN,
  input  logic          startCtrlN,
  input  logic          startHostN,
  input  logic          advN,
  input  logic          burstOrder,
  input  logic [1:0]    sleep,
  output memStrobe_t    strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          conflictErr
);

  logic          startAcc, advAcc;
  logic          active, isWrite, bankValid, bankSel, conflictQ;
  logic [AW-1:0] baseAddr;
  logic [1:0]    beat, curOff, nextBeat, nextOff;
  logic          wrGo, wrValid, wrBankC;
  logic [1:0]    wrStrobeC;

  assign startAcc = !startCtrlN || !startHostN;
  assign advAcc   = !startAcc && !advN && active;
  assign nextBeat = beat + 2'd1;

  // Offset inside the aligned four-word group for the next beat.
  always_comb begin
    if (burstOrder) nextOff = baseAddr[1:0] + nextBeat;
    else            nextOff = baseAddr[1:0] ^ nextBeat;
  end

  // Early write target: decided from the inputs of the current edge.
  always_comb begin
    wrGo    = 1'b0;
    wrValid = 1'b0;
    wrBankC = 1'b0;
    wrAddr  = addr;
    if (startAcc && !writeEnN) begin
      wrGo    = 1'b1;
      wrValid = (bankEnN != 2'b11);
      wrBankC = !bankEnN[1];
      wrAddr  = addr;
    end else if (advAcc && !writeEnN) begin
      wrGo    = 1'b1;
      wrValid = bankValid;
      wrBankC = bankSel;
      wrAddr  = {baseAddr[AW-1:2], nextOff};
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_wrGate
    assign wrStrobeC[b] = wrGo && wrValid && (wrBankC == 1'(b)) && !sleep[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      isWrite   <= 1'b0;
      bankValid <= 1'b0;
      bankSel   <= 1'b0;
      baseAddr  <= '0;
      beat      <= 2'd0;
      curOff    <= 2'd0;
      conflictQ <= 1'b0;
    end else begin
      conflictQ <= startAcc && (bankEnN == 2'b00);
      if (startAcc) begin
        active    <= 1'b1;
        isWrite   <= !writeEnN;
        bankValid <= (bankEnN != 2'b11);
        bankSel   <= !bankEnN[1];
        baseAddr  <= addr;
        beat      <= 2'd0;
        curOff    <= addr[1:0];
      end else if (advAcc) begin
        isWrite <= !writeEnN;
        beat    <= nextBeat;
        curOff  <= nextOff;
      end
    end
  end

  assign rdAddr          = {baseAddr[AW-1:2], curOff};
  assign conflictErr     = conflictQ;
  assign strobe.wrStrobe = wrStrobeC;
  assign strobe.rdActive = active && !isWrite && bankValid;
  assign strobe.rdBank   = bankSel;

  AST_ADV_KEEPS_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    advAcc |=> rdAddr[AW-1:2] == $past(rdAddr[AW-1:2])); // R5

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    advAcc && burstOrder |=> rdAddr[1:0] == $past(rdAddr[1:0]) + 2'd1); // R6

  AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    advAcc && !burstOrder |=>
      (rdAddr[1:0] ^ $past(rdAddr[1:0])) == ($past(beat) ^ ($past(beat) + 2'd1))); // R7

  AST_SINGLE_NO_ADV: assert property (@(posedge clk) disable iff (!rstN)
    !startCtrlN |=> beat == 2'd0); // R9

  AST_BOTH_EN_BANK1: assert property (@(posedge clk) disable iff (!rstN)
    startAcc && bankEnN == 2'b00 |=> conflictErr && strobe.rdBank); // R10

endmodule

// File: rtl/burst_sram_datapath.sv
module burst_sram_datapath
  import sram2b_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DATA_W = 64,
  parameter int PAR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  memStrobe_t                strobe,
  input  logic [AW-1:0]             wrAddr,
  input  logic [AW-1:0]             rdAddr,
  input  logic                      outEnN,
  input  logic [1:0]                sleep,
  input  logic [DATA_W+PAR_W-1:0]   dataIn,
  output logic [DATA_W+PAR_W-1:0]   dataOut,
  output logic                      dataOe
);

  localparam int WORD_W = DATA_W + PAR_W;
  localparam int DEPTH  = 1 << AW;

  logic [WORD_W-1:0] rdWord [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.wrStrobe[b]) mem[wrAddr] <= dataIn;
    end

    // Flow-through: no register between the array and the output.
    assign rdWord[b] = mem[rdAddr];

    always_comb begin
      if (rstN) begin
        AST_SLEEP_NO_WRITE: assert (!(strobe.wrStrobe[b] && sleep[b])); // R11
      end
    end
  end

  assign dataOe  = strobe.rdActive && !sleep[strobe.rdBank] && !outEnN;
  assign dataOut = dataOe ? rdWord[strobe.rdBank] : '0;

  AST_WRITE_THEN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.wrStrobe) |=> !dataOe); // R4

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataOe); // R12

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !sleep[strobe.rdBank]); // R11

endmodule

// File: rtl/dual_bank_burst_sram.sv
module dual_bank_burst_sram
  import sram2b_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DATA_W = 64,
  parameter int PAR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [AW-1:0]           addr,
  input  logic [1:0]              bankEnN,
  input  logic                    writeEnN,
  input  logic                    startCtrlN,
  input  logic                    startHostN,
  input  logic                    advN,
  input  logic                    burstOrder,
  input  logic                    outEnN,
  input  logic [1:0]              sleep,
  input  logic [DATA_W+PAR_W-1:0] dataIn,
  output logic [DATA_W+PAR_W-1:0] dataOut,
  output logic                    dataOe,
  output logic                    conflictErr
);

  memStrobe_t    strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  burst_sram_ctrl #(.AW(AW)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .bankEnN(bankEnN),
    .writeEnN(writeEnN), .startCtrlN(startCtrlN), .startHostN(startHostN),
    .advN(advN), .burstOrder(burstOrder), .sleep(sleep),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .conflictErr(conflictErr)
  );

  burst_sram_datapath #(.AW(AW), .DATA_W(DATA_W), .PAR_W(PAR_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .outEnN(outEnN), .sleep(sleep), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: tb/test_dual_bank_burst_sram.sv
module test_dual_bank_burst_sram;
  localparam int AW = 8;
  localparam int WW = 72;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic [1:0]    bankEnN;
  logic          writeEnN, startCtrlN, startHostN, advN, burstOrder, outEnN;
  logic [1:0]    sleepIn;
  logic [WW-1:0] dataIn, dataOut;
  logic          dataOe, conflictErr;

  dual_bank_burst_sram #(.AW(AW)) i_dual_bank_burst_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .bankEnN(bankEnN),
    .writeEnN(writeEnN), .startCtrlN(startCtrlN), .startHostN(startHostN),
    .advN(advN), .burstOrder(burstOrder), .outEnN(outEnN), .sleep(sleepIn),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .conflictErr(conflictErr)
  );

  always #4 clk = ~clk;  // 125 MHz

  logic [WW-1:0] refMem [2][1 << AW];
  int checks = 0;
  int fails  = 0;

  function automatic logic [WW-1:0] pat(input logic b, input logic [7:0] a, input logic [7:0] salt);
    return {salt ^ a, 32'hA5C30000 | {24'h0, a}, {15'h0, b}, salt, a};
  endfunction

  task automatic chk(input string req, input string what, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic idle;
    startCtrlN = 1'b1; startHostN = 1'b1; advN = 1'b1; writeEnN = 1'b1;
  endtask

  task automatic doWrite(input logic b, input logic [7:0] a, input logic [WW-1:0] d);
    bankEnN = b ? 2'b01 : 2'b10;
    addr = a; dataIn = d; writeEnN = 1'b0; startCtrlN = 1'b0;
    tick();
    if (!sleepIn[b]) refMem[b][a] = d;
    idle();
  endtask

  task automatic doRead(input logic b, input logic [7:0] a, input string req);
    bankEnN = b ? 2'b01 : 2'b10;
    addr = a; startCtrlN = 1'b0;
    tick();
    idle();
    chk(req, "read oe", {71'h0, dataOe}, 72'h1);
    chk(req, "read data", dataOut, refMem[b][a]);
  endtask

  task automatic testReset;
    rstN = 1'b0; idle(); bankEnN = 2'b11; addr = '0; dataIn = '0;
    burstOrder = 1'b1; outEnN = 1'b0; sleepIn = 2'b00;
    tick(); tick();
    chk("R13", "oe in reset", {71'h0, dataOe}, 72'h0);
    chk("R13", "conflict in reset", {71'h0, conflictErr}, 72'h0);
    rstN = 1'b1;
    tick();
    chk("R13", "oe after reset", {71'h0, dataOe}, 72'h0);
  endtask

  task automatic testFillAndRead;
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 4; k++) begin
        doWrite(1'(b), 8'h10 + 8'(k), pat(1'(b), 8'h10 + 8'(k), 8'h3C));
        chk("R4", "quiet after write", {71'h0, dataOe}, 72'h0);
        doWrite(1'(b), 8'h24 + 8'(k), pat(1'(b), 8'h24 + 8'(k), 8'h71));
      end
    doRead(1'b0, 8'h12, "R1");
    doRead(1'b1, 8'h12, "R1");
    doRead(1'b1, 8'h27, "R3");
    // start through the processor strobe
    bankEnN = 2'b10; addr = 8'h25; startHostN = 1'b0;
    tick(); idle();
    chk("R2", "host start data", dataOut, refMem[0][8'h25]);
  endtask

  task automatic burstRead(input logic b, input logic [7:0] a, input logic order, input string req);
    logic [1:0] off;
    burstOrder = order;
    doRead(b, a, req);
    for (int k = 1; k <= 4; k++) begin
      advN = 1'b0;
      tick();
      off = order ? 2'(a[1:0] + 2'(k)) : (a[1:0] ^ 2'(k));
      chk(req, $sformatf("burst beat %0d", k), dataOut, refMem[b][{a[7:2], off}]);
    end
    chk("R5", "wrap to start", dataOut, refMem[b][a]);
    idle();
  endtask

  task automatic burstWrite(input logic b, input logic [7:0] a, input logic order);
    logic [1:0] off;
    burstOrder = order;
    bankEnN = b ? 2'b01 : 2'b10;
    addr = a; writeEnN = 1'b0; startCtrlN = 1'b0; dataIn = pat(b, a, 8'hE1);
    tick();
    refMem[b][a] = dataIn;
    startCtrlN = 1'b1;
    for (int k = 1; k < 4; k++) begin
      off = order ? 2'(a[1:0] + 2'(k)) : (a[1:0] ^ 2'(k));
      advN = 1'b0; dataIn = pat(b, {a[7:2], off}, 8'hE1 + 8'(k));
      tick();
      refMem[b][{a[7:2], off}] = dataIn;
      chk("R8", "quiet during write burst", {71'h0, dataOe}, 72'h0);
    end
    idle();
    for (int k = 0; k < 4; k++) doRead(b, {a[7:2], 2'(k)}, "R8");
  endtask

  task automatic testSingleMode;
    burstOrder = 1'b1;
    startCtrlN = 1'b0; advN = 1'b0; writeEnN = 1'b1; bankEnN = 2'b01;
    for (int k = 0; k < 4; k++) begin
      addr = 8'h26 - 8'(k);
      tick();
      chk("R9", "single access", dataOut, refMem[1][8'h26 - 8'(k)]);
    end
    idle();
  endtask

  task automatic testBanks;
    logic [WW-1:0] d;
    d = pat(1'b1, 8'h11, 8'h99);
    bankEnN = 2'b00; addr = 8'h11; dataIn = d; writeEnN = 1'b0; startCtrlN = 1'b0;
    tick();
    refMem[1][8'h11] = d;
    idle();
    chk("R10", "conflict flag", {71'h0, conflictErr}, 72'h1);
    tick();
    chk("R10", "conflict one cycle", {71'h0, conflictErr}, 72'h0);
    doRead(1'b0, 8'h11, "R10");
    doRead(1'b1, 8'h11, "R10");
    // no bank enabled: no write, no drive
    bankEnN = 2'b11; addr = 8'h12; dataIn = '1; writeEnN = 1'b0; startCtrlN = 1'b0;
    tick(); idle();
    bankEnN = 2'b11; startCtrlN = 1'b0;
    tick(); idle();
    chk("R10", "no bank no drive", {71'h0, dataOe}, 72'h0);
    doRead(1'b0, 8'h12, "R10");
    doRead(1'b1, 8'h12, "R10");
  endtask

  task automatic testSleep;
    sleepIn = 2'b01;
    doWrite(1'b0, 8'h13, 72'hFF_DEAD_BEEF_0BAD_F00D);
    sleepIn = 2'b00;
    doRead(1'b0, 8'h13, "R11");
    sleepIn = 2'b01;
    bankEnN = 2'b10; addr = 8'h10; startCtrlN = 1'b0;
    tick(); idle();
    chk("R11", "sleeping bank quiet", {71'h0, dataOe}, 72'h0);
    sleepIn = 2'b00;
    #1;
    chk("R11", "awake bank drives", dataOut, refMem[0][8'h10]);
  endtask

  task automatic testOutEnable;
    outEnN = 1'b1;
    bankEnN = 2'b01; addr = 8'h24; startCtrlN = 1'b0;
    tick(); idle();
    chk("R12", "disabled oe", {71'h0, dataOe}, 72'h0);
    outEnN = 1'b0;
    #1;
    chk("R12", "async enable oe", {71'h0, dataOe}, 72'h1);
    chk("R12", "async enable data", dataOut, refMem[1][8'h24]);
  endtask

  initial begin
    testReset();
    testFillAndRead();
    burstRead(1'b0, 8'h11, 1'b1, "R6");
    burstRead(1'b1, 8'h26, 1'b0, "R7");
    burstRead(1'b1, 8'h13, 1'b1, "R5");
    burstWrite(1'b0, 8'h42, 1'b0);
    burstWrite(1'b1, 8'h57, 1'b1);
    testSingleMode();
    testBanks();
    testSleep();
    testOutEnable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule